// File: doc/BRIEF.md
# Reset-Latched Strap and Status Pin Manager

This block owns a small group of shared device pins that carry configuration straps while the device is held in reset and carry status indications once it runs. Five pins are read as a 5-bit management address. They are read continuously while reset is asserted and once more on the first clock edge after release, and that final value is held for the rest of operation. A sixth pin gives the speed status. While in reset this pin is read as an active-low pause-advertise strap, and the strap drives the pause-ability bit of the auto-negotiation advertisement register.

After release, four of the five address pins become active-low outputs: link-partner pause ability, traffic activity, collision and duplex. The fifth address pin stays input-only. The sixth pin drives the active-low speed indication. Output enables stay off during reset and for one further clock, so that no strap is overdriven while it is being read. A single-cycle activity pulse from the link logic is stretched to a programmable minimum width, so that short bursts remain visible on an indicator.

Top module: `strap_status_pins`

## Requirements
- R1: `addr_o` equals `strap_pin_i` as sampled at the first rising clock edge with `rst_ni` high. It then holds that value while `strap_pin_i` changes.
- R2: `strap_oe_o` is all zero while `rst_ni` is low and after the first edge following release. After the second edge it is 5'b01111, and `spd_oe_o` is 1.
- R3: Bit 3 of `strap_pin_o` (pause pin) is the inverse of `lp_pause_i` registered one clock earlier: 0 when the partner supports pause, 1 when it does not.
- R4: An `activity_i` pulse drives bit 2 of `strap_pin_o` low for exactly ACT_STRETCH clocks, counted from the edge that samples the last pulse. A new pulse restarts the full interval. The pin is high when idle.
- R5: Bit 1 of `strap_pin_o` (collision pin) is low one clock after `collision_i` is high while `full_duplex_i` is low. It stays high whenever `full_duplex_i` is high.
- R6: Bit 0 of `strap_pin_o` (duplex pin) is low one clock after full duplex is reported, and high for half duplex.
- R7: `spd_pin_o` is low one clock after `speed_100_i` is high (100 Mb/s), and high for 10 Mb/s.
- R8: `adv_pause_o` equals the inverse of `spd_pin_i` sampled at the same edge as R1. A 0 on the strap sets the bit and a 1 clears it. The bit then holds while the pin changes.
- R9: Bit 4 of `strap_pin_o` and bit 4 of `strap_oe_o` stay 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; straps are sampled while low and on release |
| strap_pin_i | input | 5 | Pad input values of the shared address pins |
| strap_pin_o | output | 5 | Pad drive values: [0] duplex, [1] collision, [2] activity, [3] pause, [4] unused |
| strap_oe_o | output | 5 | Pad output enables for the shared address pins |
| addr_o | output | 5 | Latched management address |
| spd_pin_i | input | 1 | Pad input of the speed pin, read as the active-low pause-advertise strap |
| spd_pin_o | output | 1 | Active-low speed drive value (0 = 100 Mb/s) |
| spd_oe_o | output | 1 | Output enable of the speed pin |
| adv_pause_o | output | 1 | Pause-ability bit of the advertisement register |
| lp_pause_i | input | 1 | Link partner advertises pause (from negotiation result) |
| full_duplex_i | input | 1 | Link runs full duplex |
| collision_i | input | 1 | Collision detected |
| speed_100_i | input | 1 | Link runs at 100 Mb/s |
| activity_i | input | 1 | Single-cycle transmit or receive activity pulse |

## Verification
The hardest situation to reach is the reset-release boundary. There the pins must still be read on the release edge, yet not be driven until one clock later. The stimulus changes the strap values during reset, again just before release, and again right after release. Only the value present at the release edge may end up latched, and the enables are checked edge by edge across that window. The stretcher is built with a short interval, so that both the exact pulse width and a retrigger part-way through can be counted cycle by cycle.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned PIN_DPX   = 0;
  localparam int unsigned PIN_COL   = 1;
  localparam int unsigned PIN_ACT   = 2;
  localparam int unsigned PIN_PAU   = 3;
  localparam logic [ADDR_W-1:0] DRIVE_MASK = 5'b01111;

  typedef struct packed {
    logic lp_pause;
    logic full_dpx;
    logic coll;
    logic spd100;
  } link_stat_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pin_i,
  input  logic              adv_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              adv_o,
  output logic              capture_o,
  output logic              drive_en_o
);
  logic              cap_q;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic              adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      cap_q <= 1'b0;
      en_q  <= ~cap_q;
    end
  end

  // sampled throughout reset and on the release edge
  always_ff @(posedge clk_i) begin
    if (!rst_ni || cap_q) begin
      addr_q <= pin_i;
      adv_q  <= ~adv_n_i;
    end
  end

  assign addr_o     = addr_q;
  assign adv_o      = adv_q;
  assign capture_o  = cap_q;
  assign drive_en_o = en_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_q |=> $stable(addr_q)); // R1
  AST_ADV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_q |=> $stable(adv_q)); // R8
endmodule

// File: rtl/act_stretch.sv
module act_stretch #(
  parameter int unsigned ACT_STRETCH = 1 << 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(ACT_STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(ACT_STRETCH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (pulse_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_ACT_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> active_o); // R4
endmodule

// File: rtl/status_drive.sv
module status_drive
  import strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  link_stat_t        stat_i,
  input  logic              active_i,
  output logic [ADDR_W-1:0] pin_o,
  output logic              spd_o
);
  link_stat_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= stat_i;
  end

  always_comb begin
    pin_o          = '0;
    pin_o[PIN_DPX] = ~st_q.full_dpx;
    pin_o[PIN_COL] = ~(st_q.coll & ~st_q.full_dpx);
    pin_o[PIN_ACT] = ~active_i;
    pin_o[PIN_PAU] = ~st_q.lp_pause;
  end

  assign spd_o = ~st_q.spd100;
endmodule

// File: rtl/strap_status_pins.sv
module strap_status_pins
  import strap_pkg::*;
#(
  parameter int unsigned ACT_STRETCH = 1 << 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] strap_pin_i,
  output logic [ADDR_W-1:0] strap_pin_o,
  output logic [ADDR_W-1:0] strap_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              spd_pin_i,
  output logic              spd_pin_o,
  output logic              spd_oe_o,
  output logic              adv_pause_o,
  input  logic              lp_pause_i,
  input  logic              full_duplex_i,
  input  logic              collision_i,
  input  logic              speed_100_i,
  input  logic              activity_i
);
  logic       capture;
  logic       drive_en;
  logic       act_on;
  link_stat_t stat;

  strap_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (strap_pin_i),
    .adv_n_i    (spd_pin_i),
    .addr_o     (addr_o),
    .adv_o      (adv_pause_o),
    .capture_o  (capture),
    .drive_en_o (drive_en)
  );

  act_stretch #(.ACT_STRETCH(ACT_STRETCH)) u_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (activity_i),
    .active_o (act_on)
  );

  assign stat = '{lp_pause: lp_pause_i, full_dpx: full_duplex_i,
                  coll: collision_i, spd100: speed_100_i};

  status_drive u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_i   (stat),
    .active_i (act_on),
    .pin_o    (strap_pin_o),
    .spd_o    (spd_pin_o)
  );

  for (genvar i = 0; i < ADDR_W; i++) begin : g_oe
    if (DRIVE_MASK[i]) begin : g_drv
      assign strap_oe_o[i] = drive_en;
    end else begin : g_in
      assign strap_oe_o[i] = 1'b0;
    end
  end
  assign spd_oe_o = drive_en;

  AST_NO_DRIVE_IN_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |-> (strap_oe_o == '0 && !spd_oe_o)); // R2
  AST_COL_MASKED_FDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_duplex_i |=> strap_pin_o[PIN_COL]); // R5
  AST_SPARE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_oe_o[ADDR_W-1] && !strap_pin_o[ADDR_W-1]); // R9
endmodule

// File: tb/sim_strap_status_pins.sv
module sim_strap_status_pins;
  localparam int unsigned STR = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] strap_pin_i = '0;
  logic [4:0] strap_pin_o, strap_oe_o, addr_o;
  logic       spd_pin_i = 1'b0;
  logic       spd_pin_o, spd_oe_o, adv_pause_o;
  logic       lp_pause_i = 0, full_duplex_i = 0, collision_i = 0, speed_100_i = 0, activity_i = 0;

  strap_status_pins #(.ACT_STRETCH(STR)) u0 (.*);

  always #5 clk_i = ~clk_i;

  typedef enum logic [2:0] {S_ADDR, S_OE, S_PIN, S_SPD, S_ADV} sel_e;
  typedef struct {
    sel_e       sel;
    logic [4:0] mask;
    logic [4:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [4:0] probe(sel_e s);
    case (s)
      S_ADDR:  return addr_o;
      S_OE:    return strap_oe_o;
      S_PIN:   return strap_pin_o;
      S_SPD:   return {3'b0, spd_oe_o, spd_pin_o};
      default: return {4'b0, adv_pause_o};
    endcase
  endfunction

  task automatic expect_v(sel_e s, logic [4:0] m, logic [4:0] v, string tag);
    item_t it;
    it.sel = s; it.mask = m; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      while (q.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it = q.pop_front();
        act = probe(it.sel);
        checks++;
        if ((act & it.mask) !== (it.val & it.mask)) begin
          errors++;
          $display("FAIL %s: got %b expected %b (mask %b)", it.tag, act & it.mask, it.val & it.mask, it.mask);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic act_pulse();
    @(negedge clk_i) activity_i = 1;
    tick();
    @(negedge clk_i) activity_i = 0;
  endtask

  initial begin
    strap_pin_i = 5'b10110;
    spd_pin_i = 0;
    repeat (3) tick();
    expect_v(S_OE, 5'h1f, 5'b0, "R2 oe in reset");
    expect_v(S_SPD, 5'b00010, 5'b0, "R2 spd oe in reset");
    expect_v(S_PIN, 5'b10000, 5'b0, "R9 spare pin in reset");
    @(negedge clk_i) strap_pin_i = 5'b01011;
    @(negedge clk_i) rst_ni = 1;
    tick(); // release edge
    expect_v(S_ADDR, 5'h1f, 5'b01011, "R1 addr at release");
    expect_v(S_OE, 5'h1f, 5'b0, "R2 oe one clock after release");
    expect_v(S_ADV, 5'h01, 5'b1, "R8 adv strap 0 sets bit");
    @(negedge clk_i) begin strap_pin_i = 5'b11111; spd_pin_i = 1; end
    tick();
    expect_v(S_OE, 5'h1f, 5'b01111, "R2 oe enabled");
    expect_v(S_SPD, 5'b00010, 5'b00010, "R2 spd oe enabled");
    expect_v(S_ADDR, 5'h1f, 5'b01011, "R1 addr held");
    expect_v(S_ADV, 5'h01, 5'b1, "R8 adv held");
    expect_v(S_PIN, 5'h1f, 5'b01111, "R9 idle pins, spare low");
    expect_v(S_SPD, 5'b00001, 5'b1, "R7 speed 10 high");

    @(negedge clk_i) lp_pause_i = 1;
    tick();
    expect_v(S_PIN, 5'b01000, 5'b0, "R3 pause supported low");
    @(negedge clk_i) lp_pause_i = 0;
    tick();
    expect_v(S_PIN, 5'b01000, 5'b01000, "R3 pause absent high");

    @(negedge clk_i) begin full_duplex_i = 1; collision_i = 1; end
    tick();
    expect_v(S_PIN, 5'b00001, 5'b0, "R6 full duplex low");
    expect_v(S_PIN, 5'b00010, 5'b00010, "R5 collision masked in full duplex");
    @(negedge clk_i) full_duplex_i = 0;
    tick();
    expect_v(S_PIN, 5'b00001, 5'b00001, "R6 half duplex high");
    expect_v(S_PIN, 5'b00010, 5'b0, "R5 collision half duplex low");
    @(negedge clk_i) collision_i = 0;
    tick();
    expect_v(S_PIN, 5'b00010, 5'b00010, "R5 no collision high");

    @(negedge clk_i) speed_100_i = 1;
    tick();
    expect_v(S_SPD, 5'b00001, 5'b0, "R7 speed 100 low");
    expect_v(S_ADDR, 5'h1f, 5'b01011, "R1 addr still held");

    // single pulse: low for exactly STR clocks
    expect_v(S_PIN, 5'b00100, 5'b00100, "R4 idle high");
    act_pulse();
    for (int i = 0; i < STR; i++) begin
      expect_v(S_PIN, 5'b00100, 5'b0, "R4 stretched low");
      if (i < STR - 1) tick();
    end
    tick();
    expect_v(S_PIN, 5'b00100, 5'b00100, "R4 released after interval");

    // retrigger after 3 clocks
    act_pulse();
    tick(); tick();
    act_pulse();
    for (int i = 0; i < STR; i++) begin
      expect_v(S_PIN, 5'b00100, 5'b0, "R4 retrigger low");
      if (i < STR - 1) tick();
    end
    tick();
    expect_v(S_PIN, 5'b00100, 5'b00100, "R4 retrigger released");

    // second reset: strap high clears advertisement, new address
    @(negedge clk_i) begin rst_ni = 0; strap_pin_i = 5'b10101; spd_pin_i = 1; end
    tick();
    expect_v(S_OE, 5'h1f, 5'b0, "R2 oe off on re-reset");
    @(negedge clk_i) rst_ni = 1;
    tick();
    expect_v(S_ADDR, 5'h1f, 5'b10101, "R1 second capture");
    expect_v(S_ADV, 5'h01, 5'b0, "R8 adv strap 1 clears bit");
    @(negedge clk_i) spd_pin_i = 0;
    tick();
    expect_v(S_ADV, 5'h01, 5'b0, "R8 adv held after strap change");
    expect_v(S_OE, 5'h1f, 5'b01111, "R2 re-enabled");
    expect_v(S_PIN, 5'b10000, 5'b0, "R9 spare undriven");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule